// File: doc/BRIEF.md
# Leading-Zero Count Execution Unit

This block is the execute stage of a 64-bit count-leading-zeros instruction. Each cycle it may take one 32-bit instruction word and the 64-bit value read from the source register. It checks that the word carries the count instruction and pulls out the two register indices. One clock later it presents the number of zero bits that sit above the highest set bit of the source, zero-extended to 64 bits. Alongside the count it gives a destination write-enable and, for the record form, a 4-bit condition-field update.

The stage numbers bits big-endian, so word bit 0 is the most significant. The count comes from a tree of leading-zero detectors over 4-bit groups, with log depth. The condition field is derived from a signed compare of the count against zero. Its summary-overflow bit is copied from an input flag. The stage has no carry or overflow outputs. A word that fails decode produces a miss indication and enables no write.

Top module: `lzc_exec_unit`

## Requirements
- R1: `resultValue` equals the number of zero bits above the most significant set bit of the captured `srcValue`, and bits 63:7 are always zero.
- R2: An all-zero source gives 64, and a source with bit 63 set gives 0.
- R3: A word is a hit only when `instrWord[31:26]` (big-endian bits 0–5) equals 31 and `instrWord[10:1]` (big-endian bits 21–30) equals 58. `instrWord[0]` is the record flag, so 0x7C000074 is the plain form and 0x7C000075 the record form.
- R4: `srcIndex` is taken from `instrWord[25:21]` and `dstIndex` from `instrWord[20:16]`. The slot `instrWord[15:11]` has no effect on any output.
- R5: The outputs for a word sampled with `inValid` high at a rising edge appear after that edge. `outValid` is high for exactly the cycles that follow a sampled `inValid`.
- R6: On a record-form hit, `crWriteEn` is 1 and `crField` is {LT,GT,EQ,SO} with LT in bit 3. LT is never set.
- R7: On a record-form hit, EQ (bit 1) is 1 exactly when the count is 0, GT (bit 2) is 1 exactly when the count is nonzero, and SO (bit 0) copies `soIn`.
- R8: On a hit, `rdWriteEn` is 1. When the record flag is clear, `crWriteEn` is 0 and `crField` is 0.
- R9: On a miss, `decodeMiss` is 1, `rdWriteEn` and `crWriteEn` are 0, and `resultValue` and `crField` are 0.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word and source are present |
| instrWord | input | 32 | Instruction word, big-endian bit numbering |
| srcValue | input | 64 | Source register value |
| soIn | input | 1 | Incoming summary-overflow flag |
| outValid | output | 1 | A result is present |
| decodeMiss | output | 1 | Word was not the count instruction |
| rdWriteEn | output | 1 | Write the destination register |
| srcIndex | output | 5 | Source register index |
| dstIndex | output | 5 | Destination register index |
| resultValue | output | 64 | Zero-extended leading-zero count |
| crWriteEn | output | 1 | Write condition field 0 |
| crField | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
Some properties are checked by the assertions on every cycle. LT is never raised. EQ and GT are mutually exclusive and follow the count. SO tracks the flag that was sampled. A miss never carries a write-enable, a condition write comes only with a register write, the upper result bits stay zero, and the latency is one cycle. Other behaviour can only be shown by the bench's scenarios: that the count is correct for the full range of values (all-zero, every single-bit value, and random values compared against a behavioural loop), that the indices are extracted correctly, and that the unused field has no effect.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  localparam int LZC_DATA_W  = 64;
  localparam int LZC_GROUP_W = 4;
  localparam int LZC_CNT_W   = $clog2(LZC_DATA_W) + 1;

  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXTEND_OP  = 10'd58;

  typedef struct packed {
    logic load;    // decoded hit: capture count
    logic record;  // record form: build condition field
  } lzcStrobes_t;
endpackage

// File: rtl/lzc_tree.sv
module lzc_tree #(
  parameter int DATA_W  = 64,   // must be GROUP_W times a power of two
  parameter int GROUP_W = 4,
  localparam int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  count,
  output logic              allZero
);
  localparam int NUM_GROUPS = DATA_W / GROUP_W;
  localparam int LEVELS     = $clog2(NUM_GROUPS);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int NODES = NUM_GROUPS >> l;
    logic [CNT_W-1:0] cnt  [NODES];
    logic             zero [NODES];

    if (l == 0) begin : g_leaf
      for (genvar g = 0; g < NODES; g++) begin : g_grp
        logic [GROUP_W-1:0] bits;
        assign bits = dataIn[g*GROUP_W +: GROUP_W];
        always_comb begin
          cnt[g] = CNT_W'(GROUP_W);
          for (int i = 0; i < GROUP_W; i++) begin
            if (bits[i]) cnt[g] = CNT_W'(GROUP_W - 1 - i);
          end
          zero[g] = ~|bits;
        end
      end
    end else begin : g_node
      for (genvar n = 0; n < NODES; n++) begin : g_pair
        localparam logic [CNT_W-1:0] HALF = CNT_W'(GROUP_W << (l - 1));
        assign zero[n] = g_lvl[l-1].zero[2*n+1] & g_lvl[l-1].zero[2*n];
        assign cnt[n]  = g_lvl[l-1].zero[2*n+1]
                         ? HALF + g_lvl[l-1].cnt[2*n]
                         : g_lvl[l-1].cnt[2*n+1];
      end
    end
  end

  assign count   = g_lvl[LEVELS].cnt[0];
  assign allZero = g_lvl[LEVELS].zero[0];
endmodule

// File: rtl/lzc_ctrl.sv
module lzc_ctrl
  import lzc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  output lzcStrobes_t strobes,
  output logic        outValid,
  output logic        decodeMiss,
  output logic        rdWriteEn,
  output logic        crWriteEn,
  output logic [4:0]  srcIndex,
  output logic [4:0]  dstIndex
);
  logic opHit;
  logic unusedSlot;

  // big-endian bit k of the word is instrWord[31-k]
  assign opHit      = (instrWord[31:26] == PRIMARY_OP) && (instrWord[10:1] == EXTEND_OP);
  assign unusedSlot = ^instrWord[15:11];

  assign strobes.load   = inValid & opHit;
  assign strobes.record = inValid & opHit & instrWord[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      decodeMiss <= 1'b0;
      rdWriteEn  <= 1'b0;
      crWriteEn  <= 1'b0;
      srcIndex   <= '0;
      dstIndex   <= '0;
    end else begin
      outValid   <= inValid;
      decodeMiss <= inValid & ~opHit;
      rdWriteEn  <= strobes.load;
      crWriteEn  <= strobes.record;
      if (inValid) begin
        srcIndex <= instrWord[25:21];
        dstIndex <= instrWord[20:16];
      end
    end
  end

  // R5: one-cycle latency of the valid flag
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R9: a miss never enables a write
  p_miss_no_we_r9: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss |-> (!rdWriteEn && !crWriteEn));
  // R8: a condition write always comes with a register write
  p_cr_with_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    crWriteEn |-> rdWriteEn);
endmodule

// File: rtl/lzc_datapath.sv
module lzc_datapath
  import lzc_pkg::*;
#(
  parameter int DATA_W  = LZC_DATA_W,
  parameter int GROUP_W = LZC_GROUP_W,
  localparam int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lzcStrobes_t       strobes,
  input  logic [DATA_W-1:0] srcValue,
  input  logic              soIn,
  output logic [DATA_W-1:0] resultValue,
  output logic [3:0]        crField
);
  logic [CNT_W-1:0] countComb;
  logic             srcZero;
  logic             countIsZero;

  lzc_tree #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) i_lzc_tree (
    .dataIn (srcValue),
    .count  (countComb),
    .allZero(srcZero)
  );

  assign countIsZero = (countComb == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValue <= '0;
      crField     <= '0;
    end else begin
      resultValue <= strobes.load ? {{(DATA_W-CNT_W){1'b0}}, countComb} : '0;
      crField     <= strobes.record ? {1'b0, ~countIsZero, countIsZero, soIn} : 4'b0000;
    end
  end

  // R2: the zero detector and the count tree agree on an empty source
  p_zero_is_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    srcZero |-> (countComb == CNT_W'(DATA_W)));
  // R1: the result never exceeds the count width
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    resultValue[DATA_W-1:CNT_W] == '0);
  // R6: LT is never raised
  p_no_lt_r6: assert property (@(posedge clk) disable iff (!rstN)
    !crField[3]);
  // R7: EQ and GT follow the registered count
  p_eq_gt_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.record |=> (crField[1] == (resultValue == '0)) && (crField[2] == (resultValue != '0)));
  // R7: SO copies the sampled flag
  p_so_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.record |=> crField[0] == $past(soIn));
endmodule

// File: rtl/lzc_exec_unit.sv
module lzc_exec_unit
  import lzc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic [63:0] srcValue,
  input  logic        soIn,
  output logic        outValid,
  output logic        decodeMiss,
  output logic        rdWriteEn,
  output logic [4:0]  srcIndex,
  output logic [4:0]  dstIndex,
  output logic [63:0] resultValue,
  output logic        crWriteEn,
  output logic [3:0]  crField
);
  lzcStrobes_t strobes;

  lzc_ctrl i_lzc_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .instrWord (instrWord),
    .strobes   (strobes),
    .outValid  (outValid),
    .decodeMiss(decodeMiss),
    .rdWriteEn (rdWriteEn),
    .crWriteEn (crWriteEn),
    .srcIndex  (srcIndex),
    .dstIndex  (dstIndex)
  );

  lzc_datapath #(.DATA_W(LZC_DATA_W), .GROUP_W(LZC_GROUP_W)) i_lzc_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srcValue   (srcValue),
    .soIn       (soIn),
    .resultValue(resultValue),
    .crField    (crField)
  );
endmodule

// File: tb/test_lzc_exec_unit.sv
`timescale 1ns/1ps
module test_lzc_exec_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] instrWord;
  logic [63:0] srcValue;
  logic        soIn;
  logic        outValid, decodeMiss, rdWriteEn, crWriteEn;
  logic [4:0]  srcIndex, dstIndex;
  logic [63:0] resultValue;
  logic [3:0]  crField;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lzc_exec_unit i_lzc_exec_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .srcValue(srcValue), .soIn(soIn), .outValid(outValid),
    .decodeMiss(decodeMiss), .rdWriteEn(rdWriteEn), .srcIndex(srcIndex),
    .dstIndex(dstIndex), .resultValue(resultValue), .crWriteEn(crWriteEn),
    .crField(crField)
  );

  localparam int NVEC = 10;
  localparam logic [63:0] VEC_SRC [NVEC] = '{
    64'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
    64'h4000_0000_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000,
    64'h00FF_0000_0000_0000, 64'h0000_0000_0000_0F00, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [6:0] VEC_CNT [NVEC] = '{
    7'd64, 7'd0, 7'd0, 7'd63, 7'd1, 7'd31, 7'd32, 7'd8, 7'd52, 7'd1};

  function automatic logic [31:0] mkWord(input logic rc, input logic [4:0] rs,
                                         input logic [4:0] ra, input logic [4:0] rb);
    return {6'd31, rs, ra, rb, 10'd58, rc};
  endfunction

  function automatic logic [63:0] refLzc(input logic [63:0] v);
    logic [63:0] n = 64;
    for (int i = 0; i < 64; i++) if (v[i]) n = 63 - i;
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [63:0] s, input logic so);
    @(negedge clk);
    inValid = 1'b1; instrWord = w; srcValue = s; soIn = so;
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic checkHit(input string req, input logic rc, input logic [63:0] s, input logic so);
    logic [63:0] e;
    e = refLzc(s);
    check({req, " result"}, resultValue, e);
    check({req, " rdWriteEn"}, {63'b0, rdWriteEn}, 64'd1);
    check({req, " crWriteEn"}, {63'b0, crWriteEn}, {63'b0, rc});
    check({req, " crField"}, {60'b0, crField},
          rc ? {60'b0, 1'b0, e != 0, e == 0, so} : 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; instrWord = '0; srcValue = '0; soIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10 outValid", {63'b0, outValid}, 0);
    check("R10 result", resultValue, 0);
    check("R10 crField", {60'b0, crField}, 0);
    check("R10 rdWriteEn", {63'b0, rdWriteEn}, 0);
    @(negedge clk); rstN = 1'b1;

    // R1 R2: vector table, plain form
    for (int k = 0; k < NVEC; k++) begin
      apply(mkWord(1'b0, 5'd3, 5'd4, 5'd0), VEC_SRC[k], 1'b0);
      check("R1 R2 table", resultValue, {57'b0, VEC_CNT[k]});
      checkHit("R8 table", 1'b0, VEC_SRC[k], 1'b0);
    end

    // R1: every single-bit value
    for (int k = 0; k < 64; k++) begin
      apply(mkWord(1'b0, 5'd1, 5'd2, 5'd0), 64'd1 << k, 1'b0);
      check("R1 power of two", resultValue, 64'd63 - k);
    end

    // R1 R6 R7: random values, record form, random SO
    for (int k = 0; k < 300; k++) begin
      logic [63:0] v;
      logic so;
      v  = {$urandom, $urandom} >> ($urandom % 65);
      so = 1'($urandom);
      apply(mkWord(1'b1, 5'd7, 5'd9, 5'd0), v, so);
      checkHit("R1 R6 R7 random", 1'b1, v, so);
    end

    // R2 R7: record form corners
    apply(32'h7C00_0075, 64'h0, 1'b1);
    check("R2 zero", resultValue, 64);
    check("R7 zero GT+SO", {60'b0, crField}, 64'b0101);
    apply(32'h7C00_0075, 64'h8000_0000_0000_0001, 1'b0);
    check("R2 msb", resultValue, 0);
    check("R7 msb EQ", {60'b0, crField}, 64'b0010);
    check("R6 crWriteEn", {63'b0, crWriteEn}, 1);

    // R3: exact plain-form word is a hit
    apply(32'h7C00_0074, 64'h10, 1'b1);
    check("R3 plain hit", {63'b0, decodeMiss}, 0);
    check("R8 no cr write", {63'b0, crWriteEn}, 0);
    check("R8 crField zero", {60'b0, crField}, 0);

    // R4: index extraction
    apply(mkWord(1'b0, 5'd21, 5'd10, 5'd0), 64'h1, 1'b0);
    check("R4 srcIndex", {59'b0, srcIndex}, 21);
    check("R4 dstIndex", {59'b0, dstIndex}, 10);

    // R4: unused slot has no effect
    for (int rb = 0; rb < 32; rb += 7) begin
      apply(mkWord(1'b1, 5'd5, 5'd6, 5'(rb)), 64'h0000_0100_0000_0000, 1'b0);
      checkHit("R4 slot", 1'b1, 64'h0000_0100_0000_0000, 1'b0);
      check("R4 slot dst", {59'b0, dstIndex}, 6);
      check("R4 slot miss", {63'b0, decodeMiss}, 0);
    end

    // R9 R3: wrong primary opcode
    apply({6'd30, 5'd1, 5'd2, 5'd0, 10'd58, 1'b1}, 64'h1, 1'b1);
    check("R9 primary miss", {63'b0, decodeMiss}, 1);
    check("R9 primary rdWe", {63'b0, rdWriteEn}, 0);
    check("R9 primary crWe", {63'b0, crWriteEn}, 0);
    check("R9 primary result", resultValue, 0);
    check("R9 primary cr", {60'b0, crField}, 0);
    // R9 R3: wrong extended opcode
    apply({6'd31, 5'd1, 5'd2, 5'd0, 10'd26, 1'b1}, 64'h0, 1'b1);
    check("R9 ext miss", {63'b0, decodeMiss}, 1);
    check("R9 ext rdWe", {63'b0, rdWriteEn}, 0);
    check("R9 ext result", resultValue, 0);

    // R5: valid follows input by one cycle
    apply(32'h7C00_0074, 64'h1, 1'b0);
    check("R5 valid", {63'b0, outValid}, 1);
    @(posedge clk); #1;
    check("R5 idle", {63'b0, outValid}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule